// File: doc/BRIEF.md
# Auto-Incrementing Colour Map Port

This block holds a colour palette of 260 entries, each with an 8-bit red, green and blue value. Entries 0 to 255 serve ordinary pixel codes; entries 256 to 259 form a small overlay bank used for cursor colours. A processor reaches the palette through a 32-bit register bus with four word offsets. It first loads a pointer, then streams colour bytes, which arrive in the top byte of the data word. An internal three-step sequencer walks red, then green, then blue. After the blue step it moves the pointer on by one, so a whole run of colours can be loaded or read back without reloading the pointer.

A second port, read-only, serves the display pipeline. It takes an entry number and returns that entry's 24-bit colour one cycle later.

Top module: `cmap_port`

## Requirements
- R1: A bus write at offset 0 loads the pointer from data bits 31:24 and returns the sequencer to the red step, even if a colour triple was half written.
- R2: Bus writes at offset 4 store data bits 31:24 into the entry selected by the pointer: red on the first write, green on the second and blue on the third.
- R3: Bus writes at offset 12 follow the same red/green/blue steps but land in overlay entry 256 + (pointer mod 4); the pixel entry selected by the pointer is left unchanged.
- R4: After the blue step of a write at offset 4 or 12, the pointer advances by one modulo 256 (255 wraps to 0) and the sequencer goes back to red.
- R5: A bus read returns the component of the current step from the pointer's entry in bits 31:24, with bits 23:0 zero, on busRdata the cycle after busRd. Reads share the step sequence with writes and advance the pointer after blue.
- R6: A bus write at any offset other than 0, 4 or 12 (for example 8) changes neither the palette, nor the pointer, nor the step.
- R7: After reset every entry is black except entries 255, 256 and 258, which are white (0xFFFFFF); the pointer and the step are zero.
- R8: lookColor shows {red, green, blue} (red in bits 23:16, blue in 7:0) of entry lookIdx one cycle after lookIdx is presented. A palette write made at one clock edge is seen by a lookup sampled at the next edge. An entry number of 260 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 4 | Byte offset in the register window |
| busWdata | input | 32 | Write data; the colour byte is in bits 31:24 |
| busRdata | output | 32 | Read data, registered, valid the cycle after busRd |
| lookIdx | input | 9 | Display lookup entry number |
| lookColor | output | 24 | Registered colour of the looked-up entry |

## Verification
The assertions take for granted that busWr and busRd are never high in the same cycle. With both high, the sequencer would advance once while the write and the read each claimed the same step, so the expected behaviour is undefined. The bench drives every bus access through one of two tasks, and each task raises exactly one strobe for exactly one cycle, so the stimulus never produces the overlap. The checker also flags the overlap directly.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  localparam int NUM_MAIN  = 256;
  localparam int NUM_OVL   = 4;
  localparam int NUM_ENT   = NUM_MAIN + NUM_OVL;
  localparam int COMP_W    = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int IDX_W     = $clog2(NUM_ENT);
  localparam int PTR_W     = $clog2(NUM_MAIN);
  localparam int OVL_W     = $clog2(NUM_OVL);
  localparam int COLOR_W   = 3 * COMP_W;

  localparam logic [ADDR_W-1:0] OFF_PTR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MAIN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_OVL  = ADDR_W'(12);

  typedef enum logic [1:0] {STEP_RED = 2'd0, STEP_GRN = 2'd1, STEP_BLU = 2'd2} step_e;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrEntry;
    step_e             wrComp;
    logic [COMP_W-1:0] wrVal;
    logic              rdEn;
    logic [IDX_W-1:0]  rdEntry;
    step_e             rdComp;
  } cmapStrobe_t;
endpackage

// File: rtl/cmap_seq.sv
module cmap_seq
  import cmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output cmapStrobe_t       strobe
);
  logic [PTR_W-1:0]  ptr;
  step_e             step;
  logic              loadPtr;
  logic              colorWr;
  logic              advance;
  logic [COMP_W-1:0] topByte;

  assign topByte = busWdata[DATA_W-1 -: COMP_W];
  assign loadPtr = busWr && (busAddr == OFF_PTR);
  assign colorWr = busWr && ((busAddr == OFF_MAIN) || (busAddr == OFF_OVL));
  assign advance = colorWr || busRd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      step <= STEP_RED;
    end else if (loadPtr) begin
      ptr  <= topByte[PTR_W-1:0];
      step <= STEP_RED;
    end else if (advance) begin
      case (step)
        STEP_RED: step <= STEP_GRN;
        STEP_GRN: step <= STEP_BLU;
        default: begin
          step <= STEP_RED;
          ptr  <= ptr + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.wrEn    = colorWr;
    strobe.wrComp  = step;
    strobe.wrVal   = topByte;
    strobe.rdEn    = busRd;
    strobe.rdComp  = step;
    strobe.rdEntry = IDX_W'(ptr);
    if (busAddr == OFF_OVL)
      strobe.wrEntry = IDX_W'(NUM_MAIN) + IDX_W'(ptr[OVL_W-1:0]);
    else
      strobe.wrEntry = IDX_W'(ptr);
  end

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWr && busRd));
  a_r4_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
    step != 2'd3);
  a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    loadPtr |=> (ptr == $past(topByte[PTR_W-1:0])) && (step == STEP_RED));
  a_r4_blue_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (colorWr && step == STEP_BLU) |=> (step == STEP_RED) && (ptr == PTR_W'($past(ptr) + 1'b1)));
  a_r6_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && !loadPtr && !colorWr) |=> $stable(ptr) && $stable(step));
endmodule

// File: rtl/cmap_store.sv
module cmap_store
  import cmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cmapStrobe_t        strobe,
  input  logic [IDX_W-1:0]   lookIdx,
  output logic [DATA_W-1:0]  busRdata,
  output logic [COLOR_W-1:0] lookColor
);
  logic [COMP_W-1:0] palR [NUM_ENT];
  logic [COMP_W-1:0] palG [NUM_ENT];
  logic [COMP_W-1:0] palB [NUM_ENT];

  function automatic logic isWhite(int e);
    return (e == NUM_MAIN - 1) || (e == NUM_MAIN) || (e == NUM_MAIN + 2);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        palR[e] <= isWhite(e) ? '1 : '0;
        palG[e] <= isWhite(e) ? '1 : '0;
        palB[e] <= isWhite(e) ? '1 : '0;
      end
    end else if (strobe.wrEn) begin
      case (strobe.wrComp)
        STEP_RED: palR[strobe.wrEntry] <= strobe.wrVal;
        STEP_GRN: palG[strobe.wrEntry] <= strobe.wrVal;
        default:  palB[strobe.wrEntry] <= strobe.wrVal;
      endcase
    end
  end

  logic [COMP_W-1:0] rdByte;
  always_comb begin
    case (strobe.rdComp)
      STEP_RED: rdByte = palR[strobe.rdEntry];
      STEP_GRN: rdByte = palG[strobe.rdEntry];
      default:  rdByte = palB[strobe.rdEntry];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busRdata  <= '0;
      lookColor <= '0;
    end else begin
      if (strobe.rdEn)
        busRdata <= {rdByte, {(DATA_W-COMP_W){1'b0}}};
      if (lookIdx < IDX_W'(NUM_ENT))
        lookColor <= {palR[lookIdx], palG[lookIdx], palB[lookIdx]};
      else
        lookColor <= '0;
    end
  end

  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lookIdx >= IDX_W'(NUM_ENT)) |=> (lookColor == '0));
  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busRdata[DATA_W-COMP_W-1:0] == '0);
  a_r2_red_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.wrComp == STEP_RED) |=> palR[$past(strobe.wrEntry)] == $past(strobe.wrVal));
endmodule

// File: rtl/cmap_port.sv
module cmap_port
  import cmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [IDX_W-1:0]   lookIdx,
  output logic [COLOR_W-1:0] lookColor
);
  cmapStrobe_t strobe;

  cmap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe)
  );

  cmap_store u_store (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .lookIdx(lookIdx),
    .busRdata(busRdata), .lookColor(lookColor)
  );
endmodule

// File: tb/test_cmap_port.sv
module test_cmap_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [8:0]  lookIdx = '0;
  logic [23:0] lookColor;

  int errors = 0;
  int checks = 0;

  logic [7:0] mR [260];
  logic [7:0] mG [260];
  logic [7:0] mB [260];
  int mPtr;
  int mStep;

  cmap_port i_cmap_port (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .lookIdx(lookIdx), .lookColor(lookColor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mColor(int e);
    if (e >= 260) return 24'h0;
    return {mR[e], mG[e], mB[e]};
  endfunction

  task automatic modelStep();
    if (mStep == 2) begin
      mStep = 0;
      mPtr = (mPtr + 1) % 256;
    end else mStep++;
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] b);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = {b, 24'h5A5A5A};
    @(negedge clk);
    busWr = 1'b0;
    if (a == 4'd0) begin
      mPtr = b; mStep = 0;
    end else if (a == 4'd4 || a == 4'd12) begin
      automatic int e = (a == 4'd12) ? 256 + (mPtr % 4) : mPtr;
      if (mStep == 0) mR[e] = b;
      else if (mStep == 1) mG[e] = b;
      else mB[e] = b;
      modelStep();
    end
  endtask

  task automatic busRead(string req);
    automatic logic [7:0] exp;
    @(negedge clk);
    busRd = 1'b1; busAddr = 4'd4;
    exp = (mStep == 0) ? mR[mPtr] : (mStep == 1) ? mG[mPtr] : mB[mPtr];
    @(negedge clk);
    busRd = 1'b0;
    check(req, busRdata, {exp, 24'h0});
    modelStep();
  endtask

  task automatic lookup(string req, int e);
    @(negedge clk);
    lookIdx = 9'(e);
    @(negedge clk);
    check(req, {8'h0, lookColor}, {8'h0, mColor(e)});
  endtask

  task automatic writeTriple(logic [3:0] a, logic [23:0] c);
    busWrite(a, c[23:16]);
    busWrite(a, c[15:8]);
    busWrite(a, c[7:0]);
  endtask

  task automatic t_reset();
    lookup("R7 entry0", 0);
    lookup("R7 entry255", 255);
    lookup("R7 entry256", 256);
    lookup("R7 entry257", 257);
    lookup("R7 entry258", 258);
    lookup("R7 entry259", 259);
    check("R7 white value", {8'h0, mColor(258)}, 32'h00FFFFFF);
    busRead("R7 ptr zero red");
    busRead("R7 ptr zero green");
    busRead("R7 ptr zero blue");
  endtask

  task automatic t_main();
    busWrite(4'd0, 8'd5);
    writeTriple(4'd4, 24'h123456);
    lookup("R2 entry5", 5);
    check("R2 entry5 value", {8'h0, mColor(5)}, 32'h00123456);
    writeTriple(4'd4, 24'hABCDEF);
    lookup("R4 next entry6", 6);
    lookup("R2 entry7 untouched", 7);
  endtask

  task automatic t_wrap();
    busWrite(4'd0, 8'd255);
    writeTriple(4'd4, 24'h0F1E2D);
    writeTriple(4'd4, 24'h778899);
    lookup("R4 entry255", 255);
    lookup("R4 wrapped entry0", 0);
    check("R4 wrapped value", {8'h0, mColor(0)}, 32'h00778899);
    lookup("R4 overlay256 untouched", 256);
  endtask

  task automatic t_overlay();
    busWrite(4'd0, 8'h0A);
    writeTriple(4'd12, 24'h102030);
    lookup("R3 overlay258", 258);
    check("R3 overlay value", {8'h0, mColor(258)}, 32'h00102030);
    lookup("R3 main10 unchanged", 10);
    writeTriple(4'd12, 24'h405060);
    lookup("R3 overlay259", 259);
    lookup("R3 main11 unchanged", 11);
  endtask

  task automatic t_read();
    busWrite(4'd0, 8'd5);
    busRead("R5 red");
    busRead("R5 green");
    busRead("R5 blue");
    busRead("R5 next entry red");
    busWrite(4'd0, 8'd6);
    busWrite(4'd4, 8'h99);
    busRead("R5 shared step green");
  endtask

  task automatic t_ignore();
    busWrite(4'd0, 8'd20);
    busWrite(4'd4, 8'h11);
    busWrite(4'd8, 8'hEE);
    busWrite(4'd2, 8'hDD);
    busWrite(4'd4, 8'h22);
    busWrite(4'd4, 8'h33);
    lookup("R6 entry20 sequence intact", 20);
    check("R6 entry20 value", {8'h0, mColor(20)}, 32'h00112233);
    lookup("R6 overlay257 untouched", 257);
    lookup("R6 entry238 untouched", 238);
  endtask

  task automatic t_restart();
    busWrite(4'd0, 8'd30);
    busWrite(4'd4, 8'h44);
    busWrite(4'd0, 8'd40);
    writeTriple(4'd4, 24'hC0C1C2);
    lookup("R1 entry30 red only", 30);
    lookup("R1 entry40 from red", 40);
  endtask

  task automatic t_latency();
    busWrite(4'd0, 8'd50);
    busWrite(4'd4, 8'h01);
    busWrite(4'd4, 8'h02);
    @(negedge clk);
    lookIdx = 9'd50;
    @(negedge clk);
    check("R8 before write", {8'h0, lookColor}, {8'h0, mColor(50)});
    busWrite(4'd4, 8'h03);
    check("R8 one cycle lag", {8'h0, lookColor}, 32'h00010200);
    @(negedge clk);
    check("R8 visible next", {8'h0, lookColor}, 32'h00010203);
    lookup("R8 out of range 260", 260);
    lookup("R8 out of range 511", 511);
  endtask

  initial begin
    for (int e = 0; e < 260; e++) begin
      automatic logic [7:0] w = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      mR[e] = w; mG[e] = w; mB[e] = w;
    end
    mPtr = 0; mStep = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 rdata reset", busRdata, 32'h0);
    t_reset();
    t_main();
    t_wrap();
    t_overlay();
    t_read();
    t_ignore();
    t_restart();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule